// File: doc/BRIEF.md
# Three-Wire Audio Clock Configuration Port

This block is the control front end of an audio clock generator. A host writes 16-bit command words over three wires: a bit clock, a data line and a framing strobe. The strobe is held low while the bits are shifted in, most significant bit first. Its rising edge then commits the word. The six top bits of the word pick one of two internal registers. The mode register holds the sample-rate family, the rate multiplier and six clock-output enables. The configuration register holds one bit that chooses the range of the selectable auxiliary clock.

The port runs on a fast system clock and samples the three wires through synchronizers. After a reset it holds the power-on defaults for a fixed number of clock cycles and accepts no write during that time. The block decodes its settings onto plain outputs. It raises a power-down flag whenever every output enable is clear, and the serial port keeps taking writes in that state so the device can be woken. An external strap pin is combined with the configuration bit to give a registered two-bit selection for the auxiliary clock.

Top module: `clkcfg_port`

## Requirements
- R1: While reset is applied and right after it, the outputs are: rate_group=00 (48 kHz family), rate_mult=00 (standard), clk_en=6'b111111, aux_cfg=0, pwr_down=0 and aux_clk_sel=00.
- R2: For POR_CYCLES system-clock cycles after reset is released, any serial write is ignored and the defaults of R1 remain.
- R3: The bits are sampled on rising edges of cfg_bclk while cfg_strobe is low, and the first bit is D15. A rising edge of cfg_strobe commits the word only if exactly 16 bits were shifted in.
- R4: A word with D15..D10 = 011100 writes the mode register. D9..D4 go to clk_en[5:0], D3..D2 go to rate_mult and D1..D0 go to rate_group.
- R5: A word with D15..D10 = 011011 writes D4 into aux_cfg. Its other low bits have no effect.
- R6: A word whose D15..D10 matches neither header changes no output.
- R7: rate_group codes are 00 = 48 kHz, 01 = 44.1 kHz and 10 = 32 kHz. A written code of 11 leaves rate_group at its previous value.
- R8: rate_mult codes are 00 = standard, 01 = double and 10 = half. A written code of 11 leaves rate_mult at its previous value.
- R9: pwr_down is 1 exactly when clk_en is all zeros. A later mode write with any enable set clears it.
- R10: A strobe rise after 15 or 17 bits loads nothing.
- R11: One clock cycle after its inputs, aux_clk_sel equals {aux_cfg, alt_pin}. The codes mean 00 = 768 fs, 01 = 512 fs, 10 = 384 fs and 11 = 256 fs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strobe | input | 1 | Serial frame strobe; its rising edge commits a word |
| cfg_bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| cfg_data | input | 1 | Serial data, MSB first |
| alt_pin | input | 1 | Strap pin that chooses the auxiliary clock range |
| rate_group | output | 2 | Sample-rate family code |
| rate_mult | output | 2 | Rate multiplier code |
| clk_en | output | 6 | Per-output clock enables |
| aux_cfg | output | 1 | Configuration bit for the auxiliary clock |
| pwr_down | output | 1 | High when all enables are clear |
| aux_clk_sel | output | 2 | Final auxiliary clock selection |

## Verification
A single mode word can clear every enable and also carry reserved rate and multiplier codes. In that one commit cycle, power-down entry and the keep-previous rule for both fields happen together. The bench sends such a word and then checks three things: pwr_down is high, clk_en is zero, and rate_group and rate_mult still hold their earlier values. It then sends a wake-up word and checks that the serial port still accepts writes while powered down.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int WORD_W = 16;
    localparam int HDR_W  = 6;
    localparam int CE_W   = 6;

    localparam logic [HDR_W-1:0] HDR_MODE = 6'b011100;
    localparam logic [HDR_W-1:0] HDR_CONF = 6'b011011;
    localparam int               CONF_BIT = 4;

    typedef enum logic [1:0] {GRP_48K, GRP_44K1, GRP_32K, GRP_RSV} grp_e;
    typedef enum logic [1:0] {MUL_STD, MUL_DBL, MUL_HALF, MUL_RSV} mul_e;
    typedef enum logic [1:0] {AUX_768, AUX_512, AUX_384, AUX_256}  auxsel_e;

    typedef struct packed {
        logic [CE_W-1:0] ce;
        mul_e            mul;
        grp_e            grp;
    } mode_t;

    typedef struct packed {
        logic [HDR_W-1:0]        hdr;
        logic [WORD_W-HDR_W-1:0] body;
    } word_t;

    localparam mode_t MODE_DEFAULT = '{ce: '1, mul: MUL_STD, grp: GRP_48K};

    function automatic logic code_reserved(input logic [1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-1:0], raw[g]};
        end
        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    end
endmodule

// File: rtl/clkcfg_shift.sv
module clkcfg_shift
    import clkcfg_pkg::*;
#(
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_rise,
    input  logic             strobe_lvl,
    input  logic             strobe_rise,
    input  logic             data_lvl,
    output logic             load_stb,
    output word_t            word,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            load_stb <= 1'b0;
            word     <= '0;
        end else begin
            load_stb <= strobe_rise && (bit_cnt == CNT_FULL);
            if (strobe_rise) word <= word_t'(shreg);
            if (strobe_lvl) begin
                bit_cnt <= '0;
            end else if (bclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], data_lvl};
                if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_stb,
    input  word_t word,
    output mode_t mode,
    output logic  aux_cfg
);
    mode_t fields;
    assign fields = mode_t'(word.body);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_DEFAULT;
            aux_cfg <= 1'b0;
        end else if (load_stb) begin
            if (word.hdr == HDR_MODE) begin
                mode.ce <= fields.ce;
                if (!code_reserved(fields.mul)) mode.mul <= fields.mul;
                if (!code_reserved(fields.grp)) mode.grp <= fields.grp;
            end else if (word.hdr == HDR_CONF) begin
                aux_cfg <= word.body[CONF_BIT];
            end
        end
    end
endmodule

// File: rtl/clkcfg_port.sv
module clkcfg_port
    import clkcfg_pkg::*;
#(
    parameter int POR_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_strobe,
    input  logic       cfg_bclk,
    input  logic       cfg_data,
    input  logic       alt_pin,
    output logic [1:0] rate_group,
    output logic [1:0] rate_mult,
    output logic [5:0] clk_en,
    output logic       aux_cfg,
    output logic       pwr_down,
    output logic [1:0] aux_clk_sel
);
    localparam int POR_W = $clog2(POR_CYCLES + 1);
    localparam int CNT_W = $clog2(WORD_W + 2);

    logic [POR_W-1:0] por_cnt;
    logic             por_busy;
    logic             core_rst;
    logic [2:0]       lvl, rise;
    logic             load_stb;
    word_t            word;
    logic [CNT_W-1:0] bit_cnt;
    mode_t            mode;
    auxsel_e          aux_sel_q;

    always_ff @(posedge clk) begin
        if (rst)           por_cnt <= '0;
        else if (por_busy) por_cnt <= por_cnt + 1'b1;
    end
    assign por_busy = (por_cnt != POR_W'(POR_CYCLES));
    assign core_rst = rst | por_busy;

    clkcfg_sync #(.LINES(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({cfg_data, cfg_bclk, cfg_strobe}),
        .lvl  (lvl),
        .rise (rise)
    );

    clkcfg_shift i_shift (
        .clk         (clk),
        .rst         (core_rst),
        .bclk_rise   (rise[1]),
        .strobe_lvl  (lvl[0]),
        .strobe_rise (rise[0]),
        .data_lvl    (lvl[2]),
        .load_stb    (load_stb),
        .word        (word),
        .bit_cnt     (bit_cnt)
    );

    clkcfg_regs i_regs (
        .clk      (clk),
        .rst      (core_rst),
        .load_stb (load_stb),
        .word     (word),
        .mode     (mode),
        .aux_cfg  (aux_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) aux_sel_q <= AUX_768;
        else     aux_sel_q <= auxsel_e'({aux_cfg, alt_pin});
    end

    assign rate_group  = mode.grp;
    assign rate_mult   = mode.mul;
    assign clk_en      = mode.ce;
    assign pwr_down    = ~|mode.ce;
    assign aux_clk_sel = aux_sel_q;
endmodule

// File: rtl/clkcfg_port_chk.sv
module clkcfg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       alt_pin,
    input logic       por_busy,
    input logic       load_stb,
    input logic [4:0] bit_cnt,
    input logic [1:0] rate_group,
    input logic [1:0] rate_mult,
    input logic [5:0] clk_en,
    input logic       aux_cfg,
    input logic [1:0] aux_clk_sel
);
    p_defaults_hold_r2: assert property (@(posedge clk) disable iff (rst)
        por_busy |-> (clk_en == 6'h3f && rate_group == 2'b00 && rate_mult == 2'b00 && !aux_cfg));

    p_commit_needs_16_r10: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> ($past(bit_cnt) == 5'd16 && bit_cnt == 5'd0));

    p_enable_change_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_en) |-> $past(load_stb));

    p_group_never_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        rate_group != 2'b11);

    p_mult_never_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        rate_mult != 2'b11);

    p_aux_follows_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> aux_clk_sel == $past({aux_cfg, alt_pin}));
endmodule

bind clkcfg_port clkcfg_port_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .alt_pin     (alt_pin),
    .por_busy    (por_busy),
    .load_stb    (load_stb),
    .bit_cnt     (bit_cnt),
    .rate_group  (rate_group),
    .rate_mult   (rate_mult),
    .clk_en      (clk_en),
    .aux_cfg     (aux_cfg),
    .aux_clk_sel (aux_clk_sel)
);

// File: tb/test_clkcfg_port.sv
module test_clkcfg_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms = 1'b1, mc = 1'b0, md = 1'b0, alt = 1'b0;
    logic [1:0] rate_group, rate_mult, aux_clk_sel;
    logic [5:0] clk_en;
    logic       aux_cfg, pwr_down;

    int errors = 0;
    int checks = 0;
    logic [1:0] e_fs = 2'b00, e_sr = 2'b00;
    logic [5:0] e_ce = 6'h3f;
    logic       e_cfg = 1'b0;

    always #10 clk = ~clk;

    clkcfg_port i_clkcfg_port (
        .clk(clk), .rst(rst), .cfg_strobe(ms), .cfg_bclk(mc), .cfg_data(md),
        .alt_pin(alt), .rate_group(rate_group), .rate_mult(rate_mult),
        .clk_en(clk_en), .aux_cfg(aux_cfg), .pwr_down(pwr_down),
        .aux_clk_sel(aux_clk_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "rate_group", rate_group, e_fs);
        chk(req, "rate_mult", rate_mult, e_sr);
        chk(req, "clk_en", clk_en, e_ce);
        chk(req, "aux_cfg", aux_cfg, e_cfg);
        chk(req, "pwr_down", pwr_down, (e_ce == 6'h00));
        chk(req, "aux_clk_sel", aux_clk_sel, {e_cfg, alt});
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        ms = 1'b0; mc = 1'b0; tick(4);
        for (int i = 0; i < nbits; i++) begin
            md = (i < 16) ? w[15-i] : 1'b0;
            mc = 1'b0; tick(4);
            mc = 1'b1; tick(4);
        end
        mc = 1'b0; tick(4);
        ms = 1'b1; tick(8);
    endtask

    function automatic void model(input logic [15:0] w);
        if (w[15:10] == 6'b011100) begin
            e_ce = w[9:4];
            if (w[3:2] != 2'b11) e_sr = w[3:2];
            if (w[1:0] != 2'b11) e_fs = w[1:0];
        end else if (w[15:10] == 6'b011011) begin
            e_cfg = w[4];
        end
    endfunction

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [15:0] w;
        tick(5);
        chk_all("R1 reset");
        rst = 1'b0;
        tick(2);
        chk_all("R1 after release");

        // R2: a write during the power-on hold is dropped
        send({6'b011100, 6'h00, 2'b01, 2'b10}, 16);
        chk_all("R2 hold");
        tick(1100);
        chk_all("R2 after hold");

        // R3 R4 R7 R8: sweep every group/mult code pair
        for (int fs = 0; fs < 4; fs++) begin
            for (int sr = 0; sr < 4; sr++) begin
                w = {6'b011100, 6'((fs * 4 + sr) * 5 + 1), 2'(sr), 2'(fs)};
                send(w, 16);
                model(w);
                chk_all("R3 R4 R7 R8 sweep");
            end
        end

        // R9 with reserved codes in the same word
        w = {6'b011100, 6'h00, 2'b11, 2'b11};
        send(w, 16); model(w);
        chk_all("R9 power-down with reserved codes");
        w = {6'b011100, 6'b100000, 2'b10, 2'b01};
        send(w, 16); model(w);
        chk_all("R9 wake");

        // R6: foreign headers change nothing
        send({6'b111111, 10'h3ff}, 16);
        chk_all("R6 header ones");
        send({6'b011101, 10'h000}, 16);
        chk_all("R6 header near mode");
        send({6'b011010, 10'h010}, 16);
        chk_all("R6 header near conf");

        // R10: wrong bit counts
        send({6'b011100, 6'h15, 2'b00, 2'b00}, 15);
        chk_all("R10 fifteen bits");
        send({6'b011100, 6'h2a, 2'b01, 2'b00}, 17);
        chk_all("R10 seventeen bits");

        // R5 R11: all config/pin combinations
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 2; p++) begin
                w = {6'b011011, 5'b11111 & 5'(c * 0), 1'(c), 4'b0000};
                send(w, 16); model(w);
                alt = 1'(p);
                tick(3);
                chk_all("R5 R11 aux select");
            end
        end
        // R5: reserved low bits have no effect
        w = {6'b011011, 5'b10101, 1'b0, 4'b1111};
        send(w, 16); model(w);
        chk_all("R5 reserved bits");

        summary();
    end
endmodule